// File: doc/BRIEF.md
# XOR Sprite Blitter with Collision Detect

This block draws one sprite into a one-bit frame buffer of 64 columns by 32 rows. A caller supplies four values with a start pulse: a byte address, a starting column, a starting row and a height of up to 15 rows. The block fetches one byte per row from a byte-wide synchronous memory. It then combines each bit of that byte with the matching screen pixel by exclusive-or, using a read-modify-write pixel port. Drawing the same sprite twice in the same place therefore removes it.

While it draws, the block records whether any lit pixel was turned off. That flag is available once the draw ends and is held until the next draw begins. A one-cycle done pulse marks the end of the draw. Each pixel coordinate wraps independently at the screen edges, so a sprite placed near a border continues on the opposite side.

The frame buffer and the sprite memory are outside the block. Both have a one-cycle read latency.

Top module: `sprite_xor_blit`

## Requirements
- R1: A draw reads sprite bytes from addresses base, base+1, … base+n-1 (modulo 2^AW), one read per row, top row first. It makes exactly n reads.
- R2: Each pixel is written with the old pixel value XOR the sprite bit. Bit 7 of a row byte maps to the starting column, and each lower bit lands one column further right. The write goes to the address that was read in the cycle before.
- R3: The pixel for row r and bit b is at column (col+b) mod 64 and line (row+r) mod 32. Its pixel address is line*64+column.
- R4: `collide` is 1 after a draw exactly when some set sprite bit met a pixel that was already lit. It is cleared when a draw is accepted, never falls during the draw, and holds its value while idle.
- R5: `done` is high for one cycle only, 18*n+1 cycles after the clock edge that accepted start. `busy` is high from the cycle after acceptance up to and including the done cycle.
- R6: A start that arrives while `busy` is high is ignored. The draw in progress, its pixels and its timing are not affected.
- R7: A height of 0 gives `done` one cycle after acceptance, with `collide` at 0. It makes no memory read and no pixel read or write.
- R8: The pixel port is never read or written in a cycle where a sprite byte is being fetched, or where the fetched byte is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a draw (accepted only when idle) |
| spr_addr | input | AW | Address of the first sprite byte |
| col | input | 8 | Starting column |
| row | input | 8 | Starting line |
| height | input | 4 | Number of sprite rows, 0..15 |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle end-of-draw pulse |
| collide | output | 1 | A lit pixel was erased by this draw |
| mem_rd | output | 1 | Sprite byte read strobe |
| mem_addr | output | AW | Sprite byte address |
| mem_data | input | 8 | Sprite byte, valid one cycle after mem_rd |
| px_rd | output | 1 | Pixel read strobe |
| px_wr | output | 1 | Pixel write strobe |
| px_addr | output | PW | Pixel address, line*COLS+column |
| px_rdata | input | 1 | Pixel value, valid one cycle after px_rd |
| px_wdata | output | 1 | New pixel value |

## Verification
Each row takes 18 cycles: one to fetch, one to wait for the byte, then a read cycle and a write cycle for each of the eight pixels. The done pulse is therefore due 18*n+1 cycles after the accepting edge. The bench counts falling edges from the start cycle and compares that count with the formula, which covers both the height-zero case and the full 15-row case. Frame-buffer contents and the collision flag are compared with a bench model only after done has appeared, when every write has reached the bench memory. Sprite fetch addresses are checked as they are issued, against the base captured when start was accepted.

// File: rtl/sprite_xor_blit.sv
module sprite_xor_blit #(
  parameter int COLS = 64,
  parameter int ROWS = 32,
  parameter int AW   = 12
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [AW-1:0]                          spr_addr,
  input  logic [7:0]                             col,
  input  logic [7:0]                             row,
  input  logic [3:0]                             height,
  output logic                                   busy,
  output logic                                   done,
  output logic                                   collide,
  output logic                                   mem_rd,
  output logic [AW-1:0]                          mem_addr,
  input  logic [7:0]                             mem_data,
  output logic                                   px_rd,
  output logic                                   px_wr,
  output logic [$clog2(COLS)+$clog2(ROWS)-1:0]   px_addr,
  input  logic                                   px_rdata,
  output logic                                   px_wdata
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_PRD, S_PWR, S_DONE} st_t;

  st_t           st;
  logic [AW-1:0] base;
  logic [7:0]    x0, y0, sbyte;
  logic [3:0]    nrows, ridx;
  logic [2:0]    bidx;
  logic          coll;

  logic          pix_bit;
  logic [CW-1:0] px_x;
  logic [RW-1:0] px_y;

  assign pix_bit  = sbyte[3'd7 - bidx];
  assign px_x     = CW'((x0 + 8'(bidx)) % COLS);
  assign px_y     = RW'((y0 + 8'(ridx)) % ROWS);
  assign px_addr  = {px_y, px_x};
  assign px_rd    = (st == S_PRD);
  assign px_wr    = (st == S_PWR);
  assign px_wdata = px_rdata ^ pix_bit;
  assign mem_rd   = (st == S_FETCH);
  assign mem_addr = base + AW'(ridx);
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign collide  = coll;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      base  <= '0;
      x0    <= '0;
      y0    <= '0;
      sbyte <= '0;
      nrows <= '0;
      ridx  <= '0;
      bidx  <= '0;
      coll  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          base  <= spr_addr;
          x0    <= col;
          y0    <= row;
          nrows <= height;
          ridx  <= '0;
          bidx  <= '0;
          coll  <= 1'b0;
          st    <= (height == 4'd0) ? S_DONE : S_FETCH;
        end
        S_FETCH: st <= S_WAIT;
        S_WAIT: begin
          sbyte <= mem_data;
          st    <= S_PRD;
        end
        S_PRD: st <= S_PWR;
        S_PWR: begin
          if (pix_bit && px_rdata) coll <= 1'b1;
          if (bidx == 3'd7) begin
            bidx <= '0;
            if (ridx == nrows - 4'd1) st <= S_DONE;
            else begin
              ridx <= ridx + 4'd1;
              st   <= S_FETCH;
            end
          end else begin
            bidx <= bidx + 3'd1;
            st   <= S_PRD;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sprite_xor_blit_chk.sv
module sprite_xor_blit_chk #(
  parameter int PW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          collide,
  input logic          mem_rd,
  input logic          px_rd,
  input logic          px_wr,
  input logic [PW-1:0] px_addr
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy); // R5
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R5
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R6
  AST_COLL_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n) (collide && busy) |=> collide); // R4
  AST_COLL_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(collide)); // R4
  AST_NO_PX_DURING_FETCH: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |-> !(px_rd || px_wr)); // R8
  AST_NO_PX_BYTE_PENDING: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> !(px_rd || px_wr)); // R8
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n) px_rd |=> (px_wr && px_addr == $past(px_addr))); // R2
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({mem_rd, px_rd, px_wr, done})); // R8
endmodule

bind sprite_xor_blit sprite_xor_blit_chk #(.PW($bits(px_addr))) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .collide(collide), .mem_rd(mem_rd), .px_rd(px_rd), .px_wr(px_wr), .px_addr(px_addr)
);

// File: tb/sprite_xor_blit_bench.sv
`timescale 1ns/1ps
module sprite_xor_blit_bench;
  localparam int AW = 12;
  localparam int NPX = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] spr_addr = '0;
  logic [7:0] col = '0, row = '0;
  logic [3:0] height = '0;
  logic busy, done, collide, mem_rd, px_rd, px_wr, px_wdata;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic [10:0] px_addr;
  logic px_rdata;

  always #5 clk = ~clk;

  sprite_xor_blit u_sprite_xor_blit (.*);

  logic [7:0] spr [1 << AW];
  logic       fb  [NPX];
  logic       efb [NPX];

  int total = 0, bad = 0;
  int rd_cnt = 0, rd_bad = 0, px_cnt = 0;
  logic [AW-1:0] cur_base = '0;

  always_ff @(posedge clk) begin
    if (mem_rd) begin
      mem_data <= spr[mem_addr];
      if (mem_addr != cur_base + AW'(rd_cnt)) rd_bad <= rd_bad + 1;
      rd_cnt <= rd_cnt + 1;
    end
    if (px_rd) px_rdata <= fb[px_addr];
    if (px_wr) begin
      fb[px_addr] <= px_wdata;
      px_cnt <= px_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_draw(input logic [AW-1:0] b, input int cx, input int ry, input int n);
    bit c = 0;
    for (int r = 0; r < n; r++) begin
      logic [7:0] byt = spr[AW'(b + AW'(r))];
      for (int k = 0; k < 8; k++) begin
        int a = ((ry + r) % 32) * 64 + ((cx + k) % 64);
        if (byt[7-k]) begin
          if (efb[a]) c = 1;
          efb[a] = ~efb[a];
        end
      end
    end
    return c;
  endfunction

  task automatic draw(input logic [AW-1:0] b, input int cx, input int ry, input int n, input bit poke_busy);
    bit ec;
    int cyc = 0, diff = 0;
    ec = model_draw(b, cx, ry, n);
    @(negedge clk);
    cur_base = b; rd_cnt = 0; rd_bad = 0; px_cnt = 0;
    spr_addr = b; col = 8'(cx); row = 8'(ry); height = 4'(n); start = 1'b1;
    @(negedge clk); cyc = 1;
    start = 1'b0;
    while (!done && cyc < 400) begin
      if (poke_busy && cyc == 5) begin
        spr_addr = b + 12'd77; col = 8'd3; row = 8'd9; height = 4'd15; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk); cyc++;
    end
    start = 1'b0;
    chk(done && cyc == 18*n+1, "R5 done latency", cyc, 18*n+1);
    @(negedge clk);
    chk(!done && !busy, "R5 done one cycle then idle", int'(done), 0);
    chk(collide == ec, n == 0 ? "R7 collide on empty draw" : "R4 collide", int'(collide), int'(ec));
    chk(rd_cnt == n && rd_bad == 0, n == 0 ? "R7 no fetch" : "R1 fetch sequence", rd_cnt, n);
    chk(px_cnt == 8*n, n == 0 ? "R7 no pixel writes" : "R2 pixel write count", px_cnt, 8*n);
    for (int i = 0; i < NPX; i++) if (fb[i] !== efb[i]) diff++;
    chk(diff == 0, poke_busy ? "R6 busy start ignored (frame)" : "R2 R3 frame contents", diff, 0);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < (1 << AW); i++) spr[i] = 8'($urandom);
    for (int i = 0; i < NPX; i++) begin fb[i] = 1'b0; efb[i] = 1'b0; end
    spr[12'h100] = 8'h80; spr[12'h101] = 8'h01; spr[12'h102] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !collide && !mem_rd && !px_rd && !px_wr, "reset state", int'(busy), 0);

    draw(12'h100, 10, 4, 3, 0);     // R2 bit order, no collision
    chk(fb[4*64+10] == 1'b1 && fb[5*64+17] == 1'b1, "R2 bit7 leftmost", int'(fb[4*64+10]), 1);
    draw(12'h100, 10, 4, 3, 0);     // R4 redraw erases, collides
    chk(fb[4*64+10] == 1'b0 && collide, "R4 redraw erases", int'(fb[4*64+10]), 0);
    draw(12'h102, 60, 31, 1, 0);    // R3 column wrap
    chk(fb[31*64+63] && fb[31*64+0] && fb[31*64+3], "R3 column wrap", int'(fb[31*64+0]), 1);
    draw(12'h102, 62, 30, 4, 0);    // R3 row and column wrap
    draw(12'hFFE, 200, 250, 4, 0);  // R1 address wrap, large coordinates
    draw(12'h055, 5, 5, 0, 0);      // R7 empty draw
    draw(12'h200, 20, 10, 15, 0);   // R5 full height
    draw(12'h300, 30, 12, 6, 1);    // R6 start while busy
    for (int t = 0; t < 30; t++)
      draw(AW'($urandom), int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 15)), t % 7 == 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule